// File: doc/BRIEF.md
# Dual Segment Base-and-Limit Address Translator

This block sits between a processor core and the memory system and turns logical addresses into physical ones. It holds two independent segments, each made of a base register and a limit register. Instruction fetches use the program segment. Loads and stores use the data segment. For each request it adds the segment base to the logical address and compares the logical address with the segment limit. An address at or above the limit is a violation. A violating request never reaches memory, and a violation flag with a per-path code is raised instead. Translation is purely combinational, so the physical address and the verdict appear in the same cycle as the request.

The four segment registers and a mode bit are programmed through a small configuration port. That port only honours writes while the core is in supervisor mode. A write attempted from user mode changes nothing and produces a one-cycle privilege error pulse. Reads return zero in user mode. While the mode bit selects bare operation, both paths pass addresses through untouched and never flag a violation. Reset selects bare operation with every base and limit at zero.

Top module: `seg_xlate_top`

## Requirements
- R1: When not bare and `if_req_i` is high with `if_addr_i` < program limit, `if_mem_req_o` is 1 and `if_paddr_o` = (program base + `if_addr_i`) modulo 2^ADDR_W.
- R2: When not bare and `dm_req_i` is high with `dm_addr_i` < data limit, `dm_mem_req_o` is 1 and `dm_paddr_o` = (data base + `dm_addr_i`) modulo 2^ADDR_W.
- R3: When not bare, a request whose address is greater than or equal to its segment limit leaves that path's memory request at 0, sets `viol_o`, and sets its bit of `viol_code_o` (bit 0 = fetch, bit 1 = data). A limit of zero makes every request on that path a violation.
- R4: Each path uses only its own segment pair. When both paths violate in the same cycle, `viol_code_o` is 2'b11.
- R5: Addresses, memory requests and violation outputs follow the request inputs combinationally, within the same cycle and with no clock edge.
- R6: In bare mode, each path's physical address equals its logical address, its memory request equals its request input, and `viol_code_o` is 0.
- R7: Configuration select codes are 0 = program base, 1 = program limit, 2 = data base, 3 = data limit, and 4 = mode (bit 0 = bare). Codes 5 to 7 are unmapped: writes there are dropped and reads return 0. A supervisor write (`cfg_priv_i`=1, `cfg_we_i`=1) takes effect from the next cycle. A supervisor read returns the register value on `cfg_rdata_o` combinationally.
- R8: A write with `cfg_priv_i`=0 changes no register. It makes `priv_err_o` high for exactly the following cycle.
- R9: While `cfg_priv_i` is 0, `cfg_rdata_o` is 0.
- R10: After reset, all bases and limits read 0, the mode bit reads 1 (bare), and `priv_err_o` is 0.
- R11: With a path's request input low, that path's memory request and violation bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_priv_i | input | 1 | Core is in supervisor mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | ADDR_W | Configuration write data |
| cfg_rdata_o | output | ADDR_W | Configuration read data (zero in user mode) |
| priv_err_o | output | 1 | One-cycle pulse after a user-mode write |
| if_req_i | input | 1 | Instruction fetch request |
| if_addr_i | input | ADDR_W | Fetch logical address |
| if_mem_req_o | output | 1 | Fetch request forwarded to memory |
| if_paddr_o | output | ADDR_W | Fetch physical address |
| dm_req_i | input | 1 | Load/store request |
| dm_addr_i | input | ADDR_W | Load/store logical address |
| dm_mem_req_o | output | 1 | Load/store request forwarded to memory |
| dm_paddr_o | output | ADDR_W | Load/store physical address |
| viol_o | output | 1 | Any limit violation this cycle |
| viol_code_o | output | 2 | Violation per path: bit 0 fetch, bit 1 data |

## Verification
A corrupted base shows up as a wrong physical address on the very first legal request of that path. A corrupted limit shows up as a request blocked or passed at the wrong boundary, so limits are probed exactly at limit-1 and at limit. A lost or stray register update surfaces one cycle later: the register read-back returns the wrong value, or the next translation goes wrong. This matters most for user-mode writes, which must leave every register and the mode bit intact. The reference model follows every register, so any such divergence is seen in the cycle where it first reaches a port.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int NUM_PATHS = 2;
    localparam int PATH_FETCH = 0;
    localparam int PATH_DATA = 1;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_PBASE  = 3'd0,
        SEL_PLIM   = 3'd1,
        SEL_DBASE  = 3'd2,
        SEL_DLIM   = 3'd3,
        SEL_MODE   = 3'd4
    } cfg_sel_e;
endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  priv_i,
    input  logic                                  we_i,
    input  logic [SEL_W-1:0]                      sel_i,
    input  logic [ADDR_W-1:0]                     wdata_i,
    output logic [ADDR_W-1:0]                     rdata_o,
    output logic                                  priv_err_o,
    output logic [NUM_PATHS-1:0][ADDR_W-1:0]      base_o,
    output logic [NUM_PATHS-1:0][ADDR_W-1:0]      lim_o,
    output logic                                  bare_o
);
    typedef struct packed {
        logic [NUM_PATHS-1:0][ADDR_W-1:0] base;
        logic [NUM_PATHS-1:0][ADDR_W-1:0] lim;
        logic                             bare;
        logic                             perr;
    } rf_t;

    rf_t st_d, st_q;
    logic wr_ok;

    assign wr_ok = we_i && priv_i;

    always_comb begin
        st_d = st_q;
        st_d.perr = we_i && !priv_i;
        if (wr_ok) begin
            case (sel_i)
                SEL_PBASE: st_d.base[PATH_FETCH] = wdata_i;
                SEL_PLIM:  st_d.lim[PATH_FETCH]  = wdata_i;
                SEL_DBASE: st_d.base[PATH_DATA]  = wdata_i;
                SEL_DLIM:  st_d.lim[PATH_DATA]   = wdata_i;
                SEL_MODE:  st_d.bare             = wdata_i[0];
                default:   st_d.bare             = st_q.bare;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{base: '0, lim: '0, bare: 1'b1, perr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (priv_i) begin
            case (sel_i)
                SEL_PBASE: rdata_o = st_q.base[PATH_FETCH];
                SEL_PLIM:  rdata_o = st_q.lim[PATH_FETCH];
                SEL_DBASE: rdata_o = st_q.base[PATH_DATA];
                SEL_DLIM:  rdata_o = st_q.lim[PATH_DATA];
                SEL_MODE:  rdata_o = {{(ADDR_W-1){1'b0}}, st_q.bare};
                default:   rdata_o = '0;
            endcase
        end
    end

    assign priv_err_o = st_q.perr;
    assign base_o     = st_q.base;
    assign lim_o      = st_q.lim;
    assign bare_o     = st_q.bare;
endmodule

// File: rtl/seg_path.sv
module seg_path #(
    parameter int ADDR_W = 32
) (
    input  logic              req_i,
    input  logic [ADDR_W-1:0] laddr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] lim_i,
    input  logic              bare_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] paddr_o,
    output logic              viol_o
);
    logic in_range;

    always_comb begin
        in_range  = laddr_i < lim_i;
        viol_o    = req_i && !bare_i && !in_range;
        mem_req_o = req_i && (bare_i || in_range);
        paddr_o   = bare_i ? laddr_i : (base_i + laddr_i);
    end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_priv_i,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [ADDR_W-1:0] cfg_wdata_i,
    output logic [ADDR_W-1:0] cfg_rdata_o,
    output logic              priv_err_o,
    input  logic              if_req_i,
    input  logic [ADDR_W-1:0] if_addr_i,
    output logic              if_mem_req_o,
    output logic [ADDR_W-1:0] if_paddr_o,
    input  logic              dm_req_i,
    input  logic [ADDR_W-1:0] dm_addr_i,
    output logic              dm_mem_req_o,
    output logic [ADDR_W-1:0] dm_paddr_o,
    output logic              viol_o,
    output logic [1:0]        viol_code_o
);
    logic [NUM_PATHS-1:0][ADDR_W-1:0] seg_base_w;
    logic [NUM_PATHS-1:0][ADDR_W-1:0] seg_lim_w;
    logic                             bare_w;
    logic [NUM_PATHS-1:0]             req_w;
    logic [NUM_PATHS-1:0][ADDR_W-1:0] laddr_w;
    logic [NUM_PATHS-1:0]             mreq_w;
    logic [NUM_PATHS-1:0][ADDR_W-1:0] paddr_w;
    logic [NUM_PATHS-1:0]             viol_w;

    seg_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .priv_i     (cfg_priv_i),
        .we_i       (cfg_we_i),
        .sel_i      (cfg_sel_i),
        .wdata_i    (cfg_wdata_i),
        .rdata_o    (cfg_rdata_o),
        .priv_err_o (priv_err_o),
        .base_o     (seg_base_w),
        .lim_o      (seg_lim_w),
        .bare_o     (bare_w)
    );

    assign req_w[PATH_FETCH]   = if_req_i;
    assign req_w[PATH_DATA]    = dm_req_i;
    assign laddr_w[PATH_FETCH] = if_addr_i;
    assign laddr_w[PATH_DATA]  = dm_addr_i;

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        seg_path #(.ADDR_W(ADDR_W)) u_path (
            .req_i     (req_w[g]),
            .laddr_i   (laddr_w[g]),
            .base_i    (seg_base_w[g]),
            .lim_i     (seg_lim_w[g]),
            .bare_i    (bare_w),
            .mem_req_o (mreq_w[g]),
            .paddr_o   (paddr_w[g]),
            .viol_o    (viol_w[g])
        );
    end

    assign if_mem_req_o = mreq_w[PATH_FETCH];
    assign if_paddr_o   = paddr_w[PATH_FETCH];
    assign dm_mem_req_o = mreq_w[PATH_DATA];
    assign dm_paddr_o   = paddr_w[PATH_DATA];
    assign viol_code_o  = viol_w;
    assign viol_o       = |viol_w;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int ADDR_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_priv_i,
    input logic                  cfg_we_i,
    input logic                  priv_err_o,
    input logic                  if_req_i,
    input logic [ADDR_W-1:0]     if_addr_i,
    input logic                  if_mem_req_o,
    input logic [ADDR_W-1:0]     if_paddr_o,
    input logic                  dm_req_i,
    input logic                  dm_mem_req_o,
    input logic [1:0]            viol_code_o,
    input logic [1:0][ADDR_W-1:0] seg_base_w,
    input logic [1:0][ADDR_W-1:0] seg_lim_w,
    input logic                  bare_w
);
    a_r3_fetch_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        viol_code_o[0] |-> !if_mem_req_o);
    a_r3_data_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        viol_code_o[1] |-> !dm_mem_req_o);
    a_r1_fetch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (if_mem_req_o && !bare_w) |-> (if_addr_i < seg_lim_w[0]));
    a_r6_bare_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (bare_w && if_req_i) |-> (if_paddr_o == if_addr_i && if_mem_req_o && viol_code_o == 2'b00));
    a_r8_perr_after_user_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && !cfg_priv_i) |=> priv_err_o);
    a_r8_perr_only_then: assert property (@(posedge clk) disable iff (!rst_n)
        priv_err_o |-> $past(cfg_we_i && !cfg_priv_i));
    a_r8_user_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && !cfg_priv_i) |=> ($stable(seg_base_w) && $stable(seg_lim_w) && $stable(bare_w)));
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_req_i && !dm_req_i) |-> (!if_mem_req_o && !dm_mem_req_o && viol_code_o == 2'b00));
endmodule

bind seg_xlate_top seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_priv_i   (cfg_priv_i),
    .cfg_we_i     (cfg_we_i),
    .priv_err_o   (priv_err_o),
    .if_req_i     (if_req_i),
    .if_addr_i    (if_addr_i),
    .if_mem_req_o (if_mem_req_o),
    .if_paddr_o   (if_paddr_o),
    .dm_req_i     (dm_req_i),
    .dm_mem_req_o (dm_mem_req_o),
    .viol_code_o  (viol_code_o),
    .seg_base_w   (seg_base_w),
    .seg_lim_w    (seg_lim_w),
    .bare_w       (bare_w)
);

// File: tb/seg_xlate_top_tb.sv
module seg_xlate_top_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_priv_i = 1'b0;
    logic          cfg_we_i = 1'b0;
    logic [2:0]    cfg_sel_i = '0;
    logic [AW-1:0] cfg_wdata_i = '0;
    logic [AW-1:0] cfg_rdata_o;
    logic          priv_err_o;
    logic          if_req_i = 1'b0;
    logic [AW-1:0] if_addr_i = '0;
    logic          if_mem_req_o;
    logic [AW-1:0] if_paddr_o;
    logic          dm_req_i = 1'b0;
    logic [AW-1:0] dm_addr_i = '0;
    logic          dm_mem_req_o;
    logic [AW-1:0] dm_paddr_o;
    logic          viol_o;
    logic [1:0]    viol_code_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [AW-1:0] m_base [2];
    logic [AW-1:0] m_lim [2];
    logic          m_bare;
    logic          m_perr;

    always #10 clk = ~clk;

    seg_xlate_top #(.ADDR_W(AW)) u_dut (.*);

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] m_read(logic [2:0] sel);
        case (sel)
            3'd0: return m_base[0];
            3'd1: return m_lim[0];
            3'd2: return m_base[1];
            3'd3: return m_lim[1];
            3'd4: return {{(AW-1){1'b0}}, m_bare};
            default: return '0;
        endcase
    endfunction

    task automatic compare_all();
        bit fv, dv;
        string ft, dt;
        fv = if_req_i && !m_bare && !(if_addr_i < m_lim[0]);
        dv = dm_req_i && !m_bare && !(dm_addr_i < m_lim[1]);
        ft = !if_req_i ? "R11" : (m_bare ? "R6" : (fv ? "R3" : "R1"));
        dt = !dm_req_i ? "R11" : (m_bare ? "R6" : (dv ? "R3" : "R2"));
        check(ft, "if_mem_req", if_mem_req_o, if_req_i && !fv);
        check(ft, "if_paddr", if_paddr_o, m_bare ? if_addr_i : AW'(m_base[0] + if_addr_i));
        check(dt, "dm_mem_req", dm_mem_req_o, dm_req_i && !dv);
        check(dt, "dm_paddr", dm_paddr_o, m_bare ? dm_addr_i : AW'(m_base[1] + dm_addr_i));
        check((fv && dv) ? "R4" : "R3", "viol_code", viol_code_o, {dv, fv});
        check("R3", "viol", viol_o, fv || dv);
        check(cfg_priv_i ? "R7" : "R9", "rdata", cfg_rdata_o, cfg_priv_i ? m_read(cfg_sel_i) : '0);
        check("R8", "priv_err", priv_err_o, m_perr);
    endtask

    // call at negedge with inputs set; checks, then advances one cycle
    task automatic cyc();
        #2;
        compare_all();
        @(posedge clk);
        m_perr = cfg_we_i && !cfg_priv_i;
        if (cfg_we_i && cfg_priv_i) begin
            case (cfg_sel_i)
                3'd0: m_base[0] = cfg_wdata_i;
                3'd1: m_lim[0]  = cfg_wdata_i;
                3'd2: m_base[1] = cfg_wdata_i;
                3'd3: m_lim[1]  = cfg_wdata_i;
                3'd4: m_bare    = cfg_wdata_i[0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(logic priv, logic [2:0] sel, logic [AW-1:0] d);
        cfg_priv_i = priv; cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
        cyc();
        cfg_we_i = 1'b0;
    endtask

    task automatic acc(logic fr, logic [AW-1:0] fa, logic dr, logic [AW-1:0] da);
        if_req_i = fr; if_addr_i = fa; dm_req_i = dr; dm_addr_i = da;
        cyc();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_base[0] = '0; m_base[1] = '0; m_lim[0] = '0; m_lim[1] = '0;
        m_bare = 1'b1; m_perr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state read back in supervisor mode
        cfg_priv_i = 1'b1;
        for (int s = 0; s < 5; s++) begin
            cfg_sel_i = 3'(s);
            #1;
            check("R10", "reset reg", cfg_rdata_o, (s == 4) ? 1 : 0);
        end
        check("R10", "reset perr", priv_err_o, 0);
        cyc();
        // R6: bare passthrough
        acc(1, 32'h1234, 1, 32'hFFFF_0000);
        acc(1, 32'h0, 0, 32'h55);
        // R8: user write to mode ignored, pulse
        wr(0, 3'd4, 32'h0);
        acc(1, 32'h40, 1, 32'h80);
        cfg_priv_i = 1'b1; cfg_sel_i = 3'd4; cyc();
        // R7: program segments and leave bare
        wr(1, 3'd0, 32'h1000);
        wr(1, 3'd1, 32'h100);
        wr(1, 3'd2, 32'h8000);
        wr(1, 3'd3, 32'h40);
        wr(1, 3'd4, 32'h0);
        wr(1, 3'd6, 32'hDEAD);
        for (int s = 0; s < 8; s++) begin cfg_sel_i = 3'(s); cyc(); end
        // R1/R2/R3 boundaries
        acc(1, 32'h0, 1, 32'h0);
        acc(1, 32'hFF, 1, 32'h3F);
        acc(1, 32'h100, 1, 32'h3F);
        acc(1, 32'hFF, 1, 32'h40);
        // R4: both violate
        acc(1, 32'hFFFF_FFFF, 1, 32'h1000);
        // R5: same-cycle response to an address change
        if_req_i = 1; if_addr_i = 32'h10; #3;
        check("R5", "paddr comb", if_paddr_o, 32'h1010);
        if_addr_i = 32'h200; #3;
        check("R5", "viol comb", viol_code_o[0], 1);
        cyc();
        // R3: zero limit on data
        wr(1, 3'd3, 32'h0);
        acc(0, 32'h0, 1, 32'h0);
        // R2: wrap-around of base + address
        wr(1, 3'd2, 32'hFFFF_FFF0);
        wr(1, 3'd3, 32'h1000);
        acc(1, 32'h4, 1, 32'h20);
        // R8/R9: user writes to bases ignored, user reads zero
        wr(0, 3'd0, 32'hAAAA);
        cfg_priv_i = 0; cfg_sel_i = 3'd0; acc(1, 32'h4, 1, 32'h20);
        cfg_priv_i = 1; cyc();
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            cfg_priv_i = 1'($urandom);
            cfg_we_i = ($urandom_range(0, 5) == 0);
            cfg_sel_i = 3'($urandom_range(0, 5));
            cfg_wdata_i = (cfg_sel_i == 3'd4) ? 32'($urandom_range(0, 3)) : 32'($urandom_range(0, 300));
            if_req_i = 1'($urandom); dm_req_i = 1'($urandom);
            if_addr_i = 32'($urandom_range(0, 320));
            dm_addr_i = ($urandom_range(0, 9) == 0) ? $urandom : 32'($urandom_range(0, 320));
            cyc();
        end
        cfg_we_i = 0;
        // R6: return to bare mode
        wr(1, 3'd4, 32'h1);
        acc(1, 32'h9999, 1, 32'h7777);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule